// File: doc/BRIEF.md
# Receive FIFO with trigger level

This block is the receive side holding buffer of a serial port. A receiver hands over each finished byte with a one-cycle push strobe. Software removes bytes with a register-read pop, which returns the oldest byte in the same cycle. The buffer holds sixteen bytes in a ring with separate write and read pointers.

A 2-bit trigger code selects the fill level that counts as "enough data". A data-ready flag follows that level, changing only when bytes move or on a flush. When the flag is up and the interrupt enable is high, the receive interrupt line goes high. The fill count is visible at all times. A synchronous flush empties the buffer in one clock.

Top module: `rx_trig_fifo`

## Requirements
- R1: After synchronous reset, fill_count is 0, ready is 0, rx_irq is 0 and pop_data reads 8'hFF.
- R2: A push (push_valid high) is accepted when rx_en is high and the fill count is below 16. It raises the count by one on the next clock. Bytes leave in arrival order, and the 16-entry ring pointers wrap from 15 to 0.
- R3: A push while rx_en is low is ignored, and the count and stored contents are unchanged.
- R4: A push while the count is 16 is discarded and the count stays 16. If a pop occurs in the same cycle, the pop is served, the push is still dropped, and the count becomes 15.
- R5: While pop is high and the buffer is not empty, pop_data shows the oldest byte in that cycle, and the count drops by one on the next clock.
- R6: While the buffer is empty, pop_data reads 8'hFF and a pop changes no state. A pop together with an accepted push on an empty buffer leaves a count of 1.
- R7: trig_sel selects the threshold: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14 entries.
- R8: After an accepted push, ready is set if the new count is at or above the threshold selected in that cycle.
- R9: After an accepted pop without a push, ready is cleared if the new count is below the threshold. Without an accepted push or pop, ready holds, even when trig_sel changes.
- R10: A push and a pop accepted in the same cycle leave the count unchanged, advance both pointers and keep the byte order. Ready then becomes 1 if the count is at or above the threshold, and 0 otherwise.
- R11: flush clears the count, both pointers and ready on the next clock, and overrides a push or pop in the same cycle.
- R12: rx_irq is high exactly while ready is 1 and rxint_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; gates pushes |
| push_valid | input | 1 | One-cycle strobe carrying a received byte |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Register-read pop strobe |
| pop_data | output | 8 | Oldest byte, or 8'hFF when empty |
| flush | input | 1 | Synchronous buffer clear |
| trig_sel | input | 2 | Threshold code |
| rxint_en | input | 1 | Receive interrupt enable |
| fill_count | output | 5 | Number of stored bytes, 0 to 16 |
| ready | output | 1 | Data-ready flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The first pattern fills the buffer one byte at a time at each threshold code. It tells whether ready rises at exactly the coded level and not one entry early or late. A second pattern fills past sixteen with pushes, then with push and pop together, and drains into the empty state. This separates correct ring wrapping and overflow dropping from pointer or count slips. A third pattern changes the trigger code or rxint_en with no traffic and applies flush during traffic. This shows the flag as sticky between transfers and the flush as dominant. A long stretch of random push, pop, enable and flush traffic is then compared cycle by cycle against a queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH = 16;
    localparam int unsigned RXQ_WIDTH = 8;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEAR    = 2'd3
    } trig_code_e;

    // operations accepted in one cycle, shared by store and level tracker
    typedef struct packed {
        logic flush;
        logic push;
        logic pop;
    } rxq_ops_t;

    // threshold for a trigger code, scaled to the buffer depth
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        case (trig_code_e'(code))
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic             pop,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    output rxq_ops_t         ops
);

    logic full;
    logic empty;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    always_comb begin
        ops.flush = flush;
        ops.push  = !flush && push_valid && rx_en && !full;
        ops.pop   = !flush && pop && !empty;
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned WIDTH = RXQ_WIDTH,
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  rxq_ops_t         ops,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WIDTH-1:0] slot_q [DEPTH];

    // pointers wrap naturally because DEPTH is a power of two
    always_ff @(posedge clk) begin
        if (rst || ops.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (ops.push) wr_ptr <= wr_ptr + 1'b1;
            if (ops.pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (ops.push && (wr_ptr == PTR_W'(i))) byte_q <= wdata;
        end
        assign slot_q[i] = byte_q;
    end

    assign head = slot_q[rd_ptr];

endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rxq_ops_t         ops,
    input  logic [1:0]       trig_sel,
    output logic [CNT_W-1:0] count,
    output logic             ready
);

    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] thresh;

    assign thresh = CNT_W'(trig_level(trig_sel, DEPTH));

    always_comb begin
        count_nxt = count;
        if (ops.push && !ops.pop)      count_nxt = count + 1'b1;
        else if (ops.pop && !ops.push) count_nxt = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || ops.flush) begin
            count <= '0;
            ready <= 1'b0;
        end else begin
            count <= count_nxt;
            if (ops.push && (count_nxt >= thresh))
                ready <= 1'b1;
            else if (ops.pop && (count_nxt < thresh))
                ready <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned WIDTH = RXQ_WIDTH,
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    input  logic             flush,
    input  logic [1:0]       trig_sel,
    input  logic             rxint_en,
    output logic [CNT_W-1:0] fill_count,
    output logic             ready,
    output logic             rx_irq
);

    rxq_ops_t         ops;
    logic [WIDTH-1:0] head;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .rx_en      (rx_en),
        .push_valid (push_valid),
        .pop        (pop),
        .flush      (flush),
        .count      (fill_count),
        .ops        (ops)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .ops   (ops),
        .wdata (push_data),
        .head  (head)
    );

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .clk      (clk),
        .rst      (rst),
        .ops      (ops),
        .trig_sel (trig_sel),
        .count    (fill_count),
        .ready    (ready)
    );

    assign pop_data = (fill_count == '0) ? '1 : head;
    assign rx_irq   = ready && rxint_en;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             push_valid,
    input logic             pop,
    input logic [WIDTH-1:0] pop_data,
    input logic             flush,
    input logic [1:0]       trig_sel,
    input logic             rxint_en,
    input logic [CNT_W-1:0] fill_count,
    input logic             ready,
    input logic             rx_irq
);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CNT_W'(DEPTH));

    // R3
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !pop && !flush) |=> $stable(fill_count));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_count == CNT_W'(DEPTH) && !pop && !flush) |=> (fill_count == CNT_W'(DEPTH)));

    // R6
    empty_data_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_count == '0) |-> (pop_data == '1));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_count == '0 && pop && !(push_valid && rx_en) && !flush) |=> (fill_count == '0));

    // R8
    trig_one_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && rx_en && !pop && !flush && trig_sel == 2'd0 && fill_count != CNT_W'(DEPTH)) |=> ready);

    // R10
    both_ops_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && rx_en && pop && !flush && fill_count != '0 && fill_count != CNT_W'(DEPTH))
        |=> $stable(fill_count));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_count == '0 && !ready));

    // R12
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && rxint_en) |-> rx_irq);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready || !rxint_en) |-> !rx_irq);

endmodule

bind rx_trig_fifo rxq_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .push_valid (push_valid),
    .pop        (pop),
    .pop_data   (pop_data),
    .flush      (flush),
    .trig_sel   (trig_sel),
    .rxint_en   (rxint_en),
    .fill_count (fill_count),
    .ready      (ready),
    .rx_irq     (rx_irq)
);

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       flush = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rxint_en = 1'b0;
    logic [4:0] fill_count;
    logic       ready;
    logic       rx_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] mq[$];
    bit         m_ready = 1'b0;

    // held configuration
    bit         c_ren = 1'b1;
    logic [1:0] c_ts = 2'd0;
    bit         c_ie = 1'b1;

    always #2 clk = ~clk;

    rx_trig_fifo u_dut (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop        (pop),
        .pop_data   (pop_data),
        .flush      (flush),
        .trig_sel   (trig_sel),
        .rxint_en   (rxint_en),
        .fill_count (fill_count),
        .ready      (ready),
        .rx_irq     (rx_irq)
    );

    function automatic int lvl(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // one clock: called at a falling edge, returns at the next falling edge
    task automatic cyc(input string tag, input bit pv, input logic [7:0] pd,
                       input bit pp, input bit fl);
        bit push_ok;
        bit pop_ok;
        int thr;
        push_valid = pv;
        push_data  = pd;
        pop        = pp;
        flush      = fl;
        rx_en      = c_ren;
        trig_sel   = c_ts;
        rxint_en   = c_ie;
        #1;
        chk(tag, "pop_data", int'(pop_data), (mq.size() > 0) ? int'(mq[0]) : 255);
        @(posedge clk);
        push_ok = pv && c_ren && (mq.size() < 16);
        pop_ok  = pp && (mq.size() > 0);
        thr     = lvl(c_ts);
        if (fl) begin
            mq.delete();
            m_ready = 1'b0;
        end else begin
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(pd);
            if (push_ok && mq.size() >= thr) m_ready = 1'b1;
            else if (pop_ok && mq.size() < thr) m_ready = 1'b0;
        end
        @(negedge clk);
        chk(tag, "fill_count", int'(fill_count), mq.size());
        chk(tag, "ready", int'(ready), int'(m_ready));
        chk(tag, "rx_irq", int'(rx_irq), int'(m_ready && c_ie));
    endtask

    task automatic push_b(input string tag, input logic [7:0] d);
        cyc(tag, 1'b1, d, 1'b0, 1'b0);
    endtask

    task automatic pop_b(input string tag);
        cyc(tag, 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "fill_count", int'(fill_count), 0);
        chk("R1", "ready", int'(ready), 0);
        chk("R1", "rx_irq", int'(rx_irq), 0);
        chk("R1", "pop_data", int'(pop_data), 255);

        // R7 R8 R12: code 0, one byte raises ready and interrupt
        c_ts = 2'd0; c_ie = 1'b1;
        push_b("R8", 8'h5A);
        pop_b("R9");
        idle("R6");

        // R3: push with receive disabled is ignored
        c_ren = 1'b0;
        push_b("R3", 8'h11);
        push_b("R3", 8'h12);
        c_ren = 1'b1;
        idle("R3");

        // R7: code 1 -> 4 entries
        c_ts = 2'd1;
        for (int i = 0; i < 4; i++) push_b("R7", 8'h20 + 8'(i));
        // R9: trigger change with no traffic keeps ready
        c_ts = 2'd3;
        idle("R9");
        pop_b("R9");
        // R12: interrupt follows the enable
        c_ts = 2'd0;
        c_ie = 1'b0;
        idle("R12");
        c_ie = 1'b1;
        idle("R12");
        for (int i = 0; i < 3; i++) pop_b("R5");
        pop_b("R6");

        // R7: code 2 -> 8, code 3 -> 14
        c_ts = 2'd2;
        for (int i = 0; i < 9; i++) push_b("R7", 8'h40 + 8'(i));
        c_ts = 2'd3;
        for (int i = 0; i < 6; i++) push_b("R7", 8'h60 + 8'(i));
        // R4: full buffer discards
        push_b("R4", 8'hEE);
        push_b("R4", 8'hEF);
        cyc("R4", 1'b1, 8'hED, 1'b1, 1'b0);
        // R10: push and pop together near full and mid
        for (int i = 0; i < 20; i++) cyc("R10", 1'b1, 8'h80 + 8'(i), 1'b1, 1'b0);
        // R5 R2: drain in order across the wrap
        for (int i = 0; i < 16; i++) pop_b("R5");
        pop_b("R6");
        // R6: pop with push on empty
        cyc("R6", 1'b1, 8'hC3, 1'b1, 1'b0);
        cyc("R10", 1'b1, 8'hC4, 1'b1, 1'b0);

        // R11: flush wins over push and pop
        c_ts = 2'd0;
        push_b("R11", 8'h01);
        push_b("R11", 8'h02);
        cyc("R11", 1'b1, 8'h03, 1'b1, 1'b1);
        idle("R11");

        // R2: random traffic against the queue model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 5) c_ts = 2'($urandom_range(0, 3));
            if (r == 7) c_ie = ~c_ie;
            c_ren = ($urandom_range(0, 9) != 0);
            cyc("R2", ($urandom_range(0, 9) < 6), 8'($urandom_range(0, 255)),
                ($urandom_range(0, 9) < 4), ($urandom_range(0, 199) == 0));
        end

        summary();
        $finish;
    end

endmodule